// File: doc/BRIEF.md
# Write-Back Cache Coherency Controller

This block keeps a small write-back data cache coherent with the rest of the system. It holds one valid bit and one modified bit for each line and acts on two kinds of external demand. The first is a snoop strobe that carries a line index and an invalidate qualifier. The second is an asynchronous, active-low flush pin. When a snoop finds a modified line, the block reports it on a hit-to-modified output and sends the whole line to the bus interface as a write-back burst request. A flush walks every line and leaves the cache empty with nothing lost.

Write-back requests leave on a valid/ready channel. `wb_req_valid` rises with `wb_req_idx`, and both stay unchanged until the cycle in which `wb_req_ready` is high. That cycle is the transfer. The bus interface then pulses `wb_done` for one cycle when the burst has finished, and the block issues no other request before that pulse. Holding `wb_req_ready` low stalls the controller for as long as it is low and loses nothing. The snoop strobe has no back-pressure: `snoop_stall` tells the system when a strobe would not be taken.

The cache's own fill and store logic updates the state bits through the fill and store ports and reads them through the lookup port. A separate input reports a replacement write-back that is already running, so that the block never writes the same line back a second time.

Top module: `wb_coherency_ctrl`

## Requirements
- R1: A snoop with invalidate low that hits a valid modified line produces a one-cycle `hitm` pulse and exactly one write-back request for that line. Once `wb_done` returns, the line is valid and clean.
- R2: A snoop with invalidate high that hits a valid modified line first writes the line back. The valid bit is cleared only after `wb_done`, and an `inval_valid` pulse carrying that index is given.
- R3: A snoop with invalidate high that hits a valid clean line invalidates it with an `inval_valid` pulse, with no write-back and no `hitm`.
- R4: A snoop with invalidate low that misses, or that hits a clean line, changes no state and produces no `hitm`, write-back or invalidation.
- R5: If the snooped modified line matches `repl_idx` while `repl_busy` is high, `hitm` still pulses but no write-back request is issued. With invalidate high, the line stays valid until `repl_busy` falls or `repl_idx` moves, and is then invalidated.
- R6: `hitm` pulses only when `wb_mode_en` was high in the cycle the snoop was evaluated. With the mode off, the write-back still happens.
- R7: While `wb_req_valid` is high and `wb_req_ready` is low, `wb_req_valid` stays high and `wb_req_idx` stays stable.
- R8: `flush_pin_n` passes through a two-stage synchronizer, and its falling edge starts a flush. The flush visits line indices 0 upward, writes back every modified line, invalidates every valid line (one `inval_valid` pulse each), and pulses `flush_done` once after line LINES-1.
- R9: A snoop taken during a flush is fully serviced before the scan moves on to its next line. The snooped line's write-back is therefore ordered ahead of write-backs of higher, unscanned lines.
- R10: A snoop strobe given while `snoop_stall` is high is ignored and leaves the cache state unchanged.
- R11: `fill_en` makes a line valid and clean. `store_en` sets the modified bit only on a valid line. `look_valid`/`look_dirty` show the state of line `look_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode_en | input | 1 | Write-back mode enable; gates `hitm` |
| snoop_req | input | 1 | Snoop strobe, one cycle |
| snoop_inv | input | 1 | Invalidate qualifier, sampled with the strobe |
| snoop_idx | input | IDX_W | Snooped line index |
| snoop_stall | output | 1 | High when a snoop strobe would be ignored |
| hitm | output | 1 | Hit-to-modified pulse |
| flush_pin_n | input | 1 | Asynchronous flush request, active low |
| flush_done | output | 1 | One-cycle pulse when a flush completes |
| repl_busy | input | 1 | A replacement write-back is running |
| repl_idx | input | IDX_W | Line of the running replacement |
| wb_req_valid | output | 1 | Write-back request valid |
| wb_req_ready | input | 1 | Bus interface accepts the request |
| wb_req_idx | output | IDX_W | Line to write back |
| wb_done | input | 1 | One-cycle pulse: write-back burst finished |
| inval_valid | output | 1 | A valid line is invalidated this cycle |
| inval_idx | output | IDX_W | Index of the invalidated line |
| fill_en | input | 1 | Mark a line valid and clean |
| fill_idx | input | IDX_W | Line being filled |
| store_en | input | 1 | Mark a valid line modified |
| store_idx | input | IDX_W | Line being stored to |
| look_idx | input | IDX_W | Line to inspect |
| look_valid | output | 1 | Valid bit of `look_idx` |
| look_dirty | output | 1 | Modified bit of `look_idx` |

## Verification
A wrong valid or modified bit shows up at the ports in one of two ways. It either produces a write-back request for a clean line or a missing one for a modified line, within two cycles of the snoop strobe. Or it shows up at `look_valid`/`look_dirty` in the same cycle it is read. An error in the sequencing state shows as an `inval_valid` pulse while that line's write-back is still outstanding, or as a broken order of requested indices during a flush. Both are visible at the first write-back or invalidation that follows. A lost synchronizer edge shows as a missing `flush_done` pulse within a few tens of cycles.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a snoop or a flush
    ST_SCAN,   // flush: examine the line at the scan pointer
    ST_SNP,    // evaluate a captured snoop
    ST_WBREQ,  // present write-back request
    ST_WBWAIT, // request taken, waiting for burst completion
    ST_RWAIT,  // line owned by a running replacement
    ST_APPLY,  // update state bits of the current line
    ST_FDONE   // flush complete pulse
  } coh_state_e;
endpackage

// File: rtl/coh_flush_sync.sv
module coh_flush_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic start_evt
);
  logic [STAGES-1:0] chain_q;
  logic              seen_q;
  logic              asserted;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], pin_n};
  end

  assign asserted = !chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= asserted;
  end

  assign start_evt = asserted && !seen_q;

  // R8: a start event is a single-cycle pulse
  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !start_evt);
endmodule

// File: rtl/coh_line_state.sv
module coh_line_state #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             store_en,
  input  logic [IDX_W-1:0] store_idx,
  input  logic             clr_en,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic             rd_a_valid,
  output logic             rd_a_dirty,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic             rd_b_valid,
  output logic             rd_b_dirty
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_clr, hit_fill, hit_store;
    assign hit_clr   = clr_en   && (clr_idx   == IDX_W'(g));
    assign hit_fill  = fill_en  && (fill_idx  == IDX_W'(g));
    assign hit_store = store_en && (store_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (hit_clr) begin
        dirty_q[g] <= 1'b0;
        if (clr_valid) valid_q[g] <= 1'b0;
      end else if (hit_fill) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= 1'b0;
      end else if (hit_store && valid_q[g]) begin
        dirty_q[g] <= 1'b1;
      end
    end
  end

  assign rd_a_valid = valid_q[rd_a_idx];
  assign rd_a_dirty = dirty_q[rd_a_idx];
  assign rd_b_valid = valid_q[rd_b_idx];
  assign rd_b_dirty = dirty_q[rd_b_idx];

  // R2: an invalidating update leaves the line invalid
  assert_clear_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && clr_valid |=> !valid_q[$past(clr_idx)]);
  // R11: a store to an invalid line never makes it modified
  assert_store_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    store_en && !valid_q[store_idx] |=> !dirty_q[$past(store_idx)]);
  // R11: modified implies valid
  assert_dirty_implies_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/coh_sequencer.sv
module coh_sequencer
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_mode_en,
  input  logic             snoop_req,
  input  logic             snoop_inv,
  input  logic [IDX_W-1:0] snoop_idx,
  output logic             snoop_stall,
  output logic             hitm,
  input  logic             flush_evt,
  output logic             flush_done,
  input  logic             repl_busy,
  input  logic [IDX_W-1:0] repl_idx,
  output logic             wb_req_valid,
  input  logic             wb_req_ready,
  output logic [IDX_W-1:0] wb_req_idx,
  input  logic             wb_done,
  output logic             inval_valid,
  output logic [IDX_W-1:0] inval_idx,
  output logic [IDX_W-1:0] cur_idx,
  input  logic             cur_valid,
  input  logic             cur_dirty,
  output logic             clr_en,
  output logic             clr_valid
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  coh_state_e       state_q;
  logic [IDX_W-1:0] snp_idx_q, scan_idx_q;
  logic             snp_inv_q, ret_scan_q, op_flush_q, flush_pend_q, hitm_q;
  logic             repl_hit, modified;
  coh_state_e       back_st;

  assign cur_idx  = (state_q == ST_SCAN || op_flush_q) ? scan_idx_q : snp_idx_q;
  assign repl_hit = repl_busy && (repl_idx == cur_idx);
  assign modified = cur_valid && cur_dirty;
  assign back_st  = ret_scan_q ? ST_SCAN : ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      snp_idx_q    <= '0;
      scan_idx_q   <= '0;
      snp_inv_q    <= 1'b0;
      ret_scan_q   <= 1'b0;
      op_flush_q   <= 1'b0;
      flush_pend_q <= 1'b0;
      hitm_q       <= 1'b0;
    end else begin
      hitm_q <= 1'b0;
      if (flush_evt) flush_pend_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (snoop_req) begin
            snp_idx_q  <= snoop_idx;
            snp_inv_q  <= snoop_inv;
            ret_scan_q <= 1'b0;
            state_q    <= ST_SNP;
          end else if (flush_pend_q) begin
            if (!flush_evt) flush_pend_q <= 1'b0;
            scan_idx_q <= '0;
            state_q    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (snoop_req) begin
            snp_idx_q  <= snoop_idx;
            snp_inv_q  <= snoop_inv;
            ret_scan_q <= 1'b1;
            state_q    <= ST_SNP;
          end else begin
            op_flush_q <= 1'b1;
            if (modified) state_q <= repl_hit ? ST_RWAIT : ST_WBREQ;
            else          state_q <= ST_APPLY;
          end
        end
        ST_SNP: begin
          hitm_q <= modified && wb_mode_en;
          if (modified) begin
            if (!repl_hit)      state_q <= ST_WBREQ;
            else if (snp_inv_q) state_q <= ST_RWAIT;
            else                state_q <= back_st;
          end else if (cur_valid && snp_inv_q) begin
            state_q <= ST_APPLY;
          end else begin
            state_q <= back_st;
          end
        end
        ST_WBREQ:  if (wb_req_ready) state_q <= ST_WBWAIT;
        ST_WBWAIT: if (wb_done)      state_q <= ST_APPLY;
        ST_RWAIT:  if (!repl_hit)    state_q <= ST_APPLY;
        ST_APPLY: begin
          if (op_flush_q) begin
            op_flush_q <= 1'b0;
            if (scan_idx_q == LAST) state_q <= ST_FDONE;
            else begin
              scan_idx_q <= scan_idx_q + IDX_W'(1);
              state_q    <= ST_SCAN;
            end
          end else begin
            state_q <= back_st;
          end
        end
        ST_FDONE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign hitm         = hitm_q;
  assign snoop_stall  = !(state_q == ST_IDLE || state_q == ST_SCAN);
  assign wb_req_valid = (state_q == ST_WBREQ);
  assign wb_req_idx   = cur_idx;
  assign clr_en       = (state_q == ST_APPLY);
  assign clr_valid    = op_flush_q || snp_inv_q;
  assign inval_valid  = clr_en && clr_valid && cur_valid;
  assign inval_idx    = cur_idx;
  assign flush_done   = (state_q == ST_FDONE);

  // R6: hit-to-modified only follows an evaluation with the mode enabled
  assert_hitm_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hitm |-> $past(wb_mode_en));
  // R7: a pending request holds its line until taken
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_valid && !wb_req_ready |=> wb_req_valid && $stable(wb_req_idx));
  // R2: no invalidation in the cycle after a write-back is handed over
  assert_no_early_inval_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_valid && wb_req_ready |=> !inval_valid);
  // R5: no write-back is requested for the line under replacement
  assert_no_dup_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_req_valid) |-> !(repl_busy && repl_idx == wb_req_idx));
  // R8: flush completion is reached only from the last line
  assert_flush_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> $past(cur_idx) == LAST && !$past(flush_done));
endmodule

// File: rtl/wb_coherency_ctrl.sv
module wb_coherency_ctrl #(
  parameter int LINES = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_mode_en,
  input  logic             snoop_req,
  input  logic             snoop_inv,
  input  logic [IDX_W-1:0] snoop_idx,
  output logic             snoop_stall,
  output logic             hitm,
  input  logic             flush_pin_n,
  output logic             flush_done,
  input  logic             repl_busy,
  input  logic [IDX_W-1:0] repl_idx,
  output logic             wb_req_valid,
  input  logic             wb_req_ready,
  output logic [IDX_W-1:0] wb_req_idx,
  input  logic             wb_done,
  output logic             inval_valid,
  output logic [IDX_W-1:0] inval_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             store_en,
  input  logic [IDX_W-1:0] store_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_valid,
  output logic             look_dirty
);
  logic             flush_evt;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_valid, cur_dirty, clr_en, clr_valid;

  coh_flush_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(flush_pin_n), .start_evt(flush_evt)
  );

  coh_line_state #(.LINES(LINES)) u_state (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_idx(fill_idx),
    .store_en(store_en), .store_idx(store_idx),
    .clr_en(clr_en), .clr_valid(clr_valid), .clr_idx(cur_idx),
    .rd_a_idx(cur_idx), .rd_a_valid(cur_valid), .rd_a_dirty(cur_dirty),
    .rd_b_idx(look_idx), .rd_b_valid(look_valid), .rd_b_dirty(look_dirty)
  );

  coh_sequencer #(.LINES(LINES)) u_seq (
    .clk(clk), .rst_n(rst_n), .wb_mode_en(wb_mode_en),
    .snoop_req(snoop_req), .snoop_inv(snoop_inv), .snoop_idx(snoop_idx),
    .snoop_stall(snoop_stall), .hitm(hitm),
    .flush_evt(flush_evt), .flush_done(flush_done),
    .repl_busy(repl_busy), .repl_idx(repl_idx),
    .wb_req_valid(wb_req_valid), .wb_req_ready(wb_req_ready),
    .wb_req_idx(wb_req_idx), .wb_done(wb_done),
    .inval_valid(inval_valid), .inval_idx(inval_idx),
    .cur_idx(cur_idx), .cur_valid(cur_valid), .cur_dirty(cur_dirty),
    .clr_en(clr_en), .clr_valid(clr_valid)
  );
endmodule

// File: tb/test_wb_coherency_ctrl.sv
module test_wb_coherency_ctrl;
  localparam int LINES = 16;
  localparam int IDX_W = 4;

  logic clk = 0, rst_n = 0, wb_mode_en = 1;
  logic snoop_req = 0, snoop_inv = 0;
  logic [IDX_W-1:0] snoop_idx = '0;
  logic snoop_stall, hitm, flush_done;
  logic flush_pin_n = 1;
  logic repl_busy = 0;
  logic [IDX_W-1:0] repl_idx = '0;
  logic wb_req_valid, wb_req_ready = 1;
  logic [IDX_W-1:0] wb_req_idx;
  logic wb_done = 0;
  logic inval_valid;
  logic [IDX_W-1:0] inval_idx;
  logic fill_en = 0, store_en = 0;
  logic [IDX_W-1:0] fill_idx = '0, store_idx = '0, look_idx = '0;
  logic look_valid, look_dirty;

  wb_coherency_ctrl #(.LINES(LINES)) i_wb_coherency_ctrl (
    .clk(clk), .rst_n(rst_n), .wb_mode_en(wb_mode_en),
    .snoop_req(snoop_req), .snoop_inv(snoop_inv), .snoop_idx(snoop_idx),
    .snoop_stall(snoop_stall), .hitm(hitm),
    .flush_pin_n(flush_pin_n), .flush_done(flush_done),
    .repl_busy(repl_busy), .repl_idx(repl_idx),
    .wb_req_valid(wb_req_valid), .wb_req_ready(wb_req_ready),
    .wb_req_idx(wb_req_idx), .wb_done(wb_done),
    .inval_valid(inval_valid), .inval_idx(inval_idx),
    .fill_en(fill_en), .fill_idx(fill_idx),
    .store_en(store_en), .store_idx(store_idx),
    .look_idx(look_idx), .look_valid(look_valid), .look_dirty(look_dirty)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bus and output monitor, all at negedge
  int hitm_cnt = 0, wb_cnt = 0, inval_cnt = 0, fdone_cnt = 0, order_err = 0;
  int lat = 3, lat_cnt = 0, stall_left = 0, stall_seen = 0;
  logic [IDX_W-1:0] stall_idx = '0, inval_last = '0, out_idx = '0;
  bit out_active = 0;
  logic [IDX_W-1:0] wb_log [64];

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      wb_done = 0;
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin wb_done = 1; out_active = 0; end
      end
      if (hitm) hitm_cnt++;
      if (flush_done) fdone_cnt++;
      if (inval_valid) begin
        inval_cnt++;
        inval_last = inval_idx;
        if (out_active && out_idx == inval_idx) order_err++;
      end
      if (wb_req_valid) begin
        if (stall_left > 0) begin
          stall_left--;
          wb_req_ready = 0;
          if (wb_req_idx == stall_idx) stall_seen++;
        end else begin
          wb_req_ready = 1;
          if (wb_cnt < 64) wb_log[wb_cnt] = wb_req_idx;
          wb_cnt++;
          lat_cnt = lat;
          out_active = 1;
          out_idx = wb_req_idx;
        end
      end else wb_req_ready = 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(input int idx);
    @(negedge clk); fill_en = 1; fill_idx = IDX_W'(idx);
    @(negedge clk); fill_en = 0;
  endtask

  task automatic store(input int idx);
    @(negedge clk); store_en = 1; store_idx = IDX_W'(idx);
    @(negedge clk); store_en = 0;
  endtask

  task automatic snoop(input int idx, input bit inv);
    @(negedge clk);
    while (snoop_stall) @(negedge clk);
    snoop_req = 1; snoop_idx = IDX_W'(idx); snoop_inv = inv;
    @(negedge clk); snoop_req = 0; snoop_inv = 0;
  endtask

  task automatic peek(input int idx, output bit v, output bit d);
    look_idx = IDX_W'(idx);
    #1;
    v = look_valid; d = look_dirty;
  endtask

  task automatic t_reset;
    bit v, d;
    check(!hitm && !wb_req_valid && !inval_valid && !flush_done && !snoop_stall,
          "reset outputs idle", int'(hitm) + int'(wb_req_valid), 0);
    peek(5, v, d);
    check(!v && !d, "R11 reset line invalid", int'(v), 0);
  endtask

  task automatic t_fill_store;  // R11
    bit v, d;
    fill(3); store(3);
    peek(3, v, d);
    check(v && d, "R11 fill then store gives valid modified", int'(d), 1);
    store(4);
    peek(4, v, d);
    check(!v && !d, "R11 store to invalid line ignored", int'(d), 0);
  endtask

  task automatic t_plain_dirty;  // R1
    bit v, d;
    int h0 = hitm_cnt, w0 = wb_cnt, i0 = inval_cnt;
    snoop(3, 0); settle(12);
    check(hitm_cnt == h0 + 1, "R1 hitm pulse", hitm_cnt - h0, 1);
    check(wb_cnt == w0 + 1 && wb_log[w0] == 3, "R1 one write-back of line 3", wb_cnt - w0, 1);
    peek(3, v, d);
    check(v && !d && inval_cnt == i0, "R1 line valid and clean after", int'(d), 0);
  endtask

  task automatic t_inv_dirty;  // R2
    bit v, d;
    int w0 = wb_cnt, i0 = inval_cnt;
    fill(6); store(6);
    snoop(6, 1); settle(12);
    check(wb_cnt == w0 + 1 && wb_log[w0] == 6, "R2 write-back of line 6", wb_cnt - w0, 1);
    check(inval_cnt == i0 + 1 && inval_last == 6, "R2 invalidate pulse line 6", int'(inval_last), 6);
    check(order_err == 0, "R2 invalidate only after done", order_err, 0);
    peek(6, v, d);
    check(!v, "R2 line 6 invalid", int'(v), 0);
  endtask

  task automatic t_inv_clean;  // R3
    bit v, d;
    int h0 = hitm_cnt, w0 = wb_cnt, i0 = inval_cnt;
    fill(7);
    snoop(7, 1); settle(8);
    check(wb_cnt == w0 && hitm_cnt == h0, "R3 no write-back or hitm", wb_cnt - w0, 0);
    check(inval_cnt == i0 + 1 && inval_last == 7, "R3 invalidate line 7", int'(inval_last), 7);
    peek(7, v, d);
    check(!v, "R3 line 7 invalid", int'(v), 0);
  endtask

  task automatic t_no_action;  // R4
    bit v, d;
    int h0 = hitm_cnt, w0 = wb_cnt, i0 = inval_cnt;
    snoop(8, 0); snoop(3, 0); snoop(8, 1); settle(8);
    check(hitm_cnt == h0 && wb_cnt == w0 && inval_cnt == i0, "R4 no activity",
          hitm_cnt + wb_cnt + inval_cnt, h0 + w0 + i0);
    peek(3, v, d);
    check(v && !d, "R4 line 3 unchanged", int'(v), 1);
  endtask

  task automatic t_repl;  // R5
    bit v, d;
    int h0 = hitm_cnt, w0 = wb_cnt, i0 = inval_cnt;
    fill(10); store(10);
    @(negedge clk); repl_busy = 1; repl_idx = 4'd10;
    snoop(10, 1); settle(10);
    check(hitm_cnt == h0 + 1, "R5 hitm during replacement", hitm_cnt - h0, 1);
    check(wb_cnt == w0, "R5 no extra write-back", wb_cnt - w0, 0);
    peek(10, v, d);
    check(v && inval_cnt == i0, "R5 held valid while replacement runs", int'(v), 1);
    @(negedge clk); repl_busy = 0;
    settle(6);
    check(inval_cnt == i0 + 1 && inval_last == 10, "R5 invalidate after replacement", inval_cnt - i0, 1);
    check(wb_cnt == w0, "R5 still no write-back", wb_cnt - w0, 0);
  endtask

  task automatic t_mode;  // R6
    int h0 = hitm_cnt, w0 = wb_cnt;
    fill(11); store(11);
    @(negedge clk); wb_mode_en = 0;
    snoop(11, 0); settle(12);
    check(hitm_cnt == h0, "R6 no hitm with mode off", hitm_cnt - h0, 0);
    check(wb_cnt == w0 + 1 && wb_log[w0] == 11, "R6 write-back still done", wb_cnt - w0, 1);
    @(negedge clk); wb_mode_en = 1;
  endtask

  task automatic t_ready;  // R7
    int w0 = wb_cnt;
    fill(12); store(12);
    @(negedge clk); stall_left = 5; stall_idx = 4'd12; stall_seen = 0;
    snoop(12, 1); settle(20);
    check(stall_seen == 5, "R7 request held stable under back-pressure", stall_seen, 5);
    check(wb_cnt == w0 + 1 && wb_log[w0] == 12, "R7 request taken once", wb_cnt - w0, 1);
  endtask

  task automatic t_stall;  // R10
    bit v, d;
    int i0;
    fill(14); fill(13); store(13);
    @(negedge clk); lat = 20;
    snoop(13, 0);
    while (!snoop_stall) @(negedge clk);
    settle(3);
    i0 = inval_cnt;
    snoop_req = 1; snoop_idx = 4'd14; snoop_inv = 1;
    @(negedge clk); snoop_req = 0; snoop_inv = 0;
    settle(30);
    peek(14, v, d);
    check(v && inval_cnt == i0, "R10 snoop during stall ignored", int'(v), 1);
    lat = 3;
  endtask

  task automatic t_flush;  // R8, R9
    bit v, d;
    int w0, i0, f0, bad = 0;
    fill(1); fill(2); fill(5); fill(9); fill(15);
    store(2); store(5); store(9);
    w0 = wb_cnt; i0 = inval_cnt; f0 = fdone_cnt;
    @(negedge clk); lat = 4; flush_pin_n = 0;
    settle(3); flush_pin_n = 1;
    while (wb_cnt == w0) @(negedge clk);
    snoop(9, 0);   // R9: serviced before the scan moves on
    for (int k = 0; k < 600 && fdone_cnt == f0; k++) @(negedge clk);
    settle(2);
    check(fdone_cnt == f0 + 1, "R8 one flush done pulse", fdone_cnt - f0, 1);
    check(wb_cnt == w0 + 3, "R8 three write-backs", wb_cnt - w0, 3);
    check(wb_log[w0] == 2 && wb_log[w0+1] == 9 && wb_log[w0+2] == 5,
          "R9 write-back order 2,9,5", int'(wb_log[w0+1]), 9);
    check(inval_cnt == i0 + 9, "R8 every valid line invalidated", inval_cnt - i0, 9);
    for (int k = 0; k < LINES; k++) begin
      peek(k, v, d);
      if (v || d) bad++;
    end
    check(bad == 0, "R8 cache empty after flush", bad, 0);
    check(order_err == 0, "R8 no invalidation before write-back", order_err, 0);
    lat = 3;
  endtask

  initial begin
    settle(3);
    rst_n = 1;
    settle(2);
    t_reset();
    t_fill_store();
    t_plain_dirty();
    t_inv_dirty();
    t_inv_clean();
    t_no_action();
    t_repl();
    t_mode();
    t_ready();
    t_stall();
    t_flush();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule